// File: doc/BRIEF.md
# Privileged Processor Flag Register

This block is the 32-bit status register of a small 32-bit processor. The low half holds five condition flags that the ALU produces: carry, overflow, zero, sign and an odd-parity flag. The high half holds three control bits: interrupt enable, user mode and paging enable. Every other bit is reserved and reads as zero.

Four sources can change the register. The ALU can refresh the condition flags. Software can write either half. A pair of commands can set or clear the interrupt-enable bit. A restore port can reload the whole word when a trap returns. While the user-mode bit is set, the control half is locked. A user-mode attempt to write it, or to use the interrupt commands, is dropped and raises a protection-fault pulse one cycle long. The current value is always visible on `flags_o`, and trap entry saves it from that port.

All controls are plain single-cycle strobes sampled on the rising clock edge. The block never stalls, so there is no handshake and no back-pressure. Every accepted command takes effect at the same edge that samples it.

Top module: `pflag_reg`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it rises, `flags_o` is 0x00000000 and `prot_fault_o` is 0. This state is supervisor mode with interrupts and paging off.
- R2: When `alu_upd_i` is high and no higher-priority source writes the low half, the register loads the ALU flags into its low bits: bit 0 = `alu_carry_i`, bit 1 = `alu_ovf_i`, bit 2 = (`alu_result_i` == 0), bit 3 = `alu_result_i[31]`, bit 4 = XOR of all 32 result bits. The upper half is not changed.
- R3: Only bits 0-4 and 16-18 can ever be 1. Every other bit reads 0 after any write or restore.
- R4: A software write (`sw_wr_i`) with `sw_be_lo_i` high loads bits 0-4 from `sw_wdata_i` in either mode, provided the same write does not fault.
- R5: In supervisor mode (bit 17 = 0), a software write with `sw_be_hi_i` high loads bits 16 (interrupt enable), 17 (user mode) and 18 (paging) from `sw_wdata_i`.
- R6: In user mode (bit 17 = 1), a software write with `sw_be_hi_i` high changes neither half of the register. It pulses `prot_fault_o` for one cycle.
- R7: In supervisor mode, `ien_set_i` sets bit 16 and `ien_clr_i` clears it. If both are high, clear wins. A software write to the high half takes priority over both.
- R8: In user mode, `ien_set_i` or `ien_clr_i` leaves the register unchanged and pulses `prot_fault_o`.
- R9: `restore_i` loads `restore_data_i` (with reserved bits forced to 0) into all bits in any mode. It overrides software writes, interrupt commands and ALU updates in the same cycle.
- R10: A non-faulting software write to the low half takes priority over a same-cycle ALU update. A faulting write does not block the ALU update.
- R11: `prot_fault_o` is high in exactly the cycle after a rejected attempt (R6, R8), whether or not a restore happens in that cycle, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_upd_i | input | 1 | Refresh condition flags from the ALU |
| alu_result_i | input | 32 | ALU result used for zero, sign and odd flags |
| alu_carry_i | input | 1 | ALU carry out |
| alu_ovf_i | input | 1 | ALU signed overflow |
| sw_wr_i | input | 1 | Software write strobe |
| sw_be_lo_i | input | 1 | Software write targets the condition half |
| sw_be_hi_i | input | 1 | Software write targets the control half |
| sw_wdata_i | input | 32 | Software write data |
| ien_set_i | input | 1 | Set interrupt enable (privileged) |
| ien_clr_i | input | 1 | Clear interrupt enable (privileged) |
| restore_i | input | 1 | Trap-return reload strobe |
| restore_data_i | input | 32 | Saved flag word to reload |
| flags_o | output | 32 | Current register value, also the save port |
| prot_fault_o | output | 1 | One-cycle protection-fault pulse |

## Verification
The ALU flag logic is driven with a zero result, results with even and odd numbers of one bits, and negative results. These patterns separate the zero, sign and parity bits from one another and from the carry and overflow inputs.

Software writes and interrupt commands are issued in both modes. This shows whether the lock depends on the stored user bit. It also shows that a rejected write leaves the low half untouched.

Same-cycle collisions of restore, software write, interrupt commands and ALU update expose any error in the priority order. A long random run against a bench reference model, which enters user mode by restore and leaves it the same way, covers the mixed cases.

// File: rtl/pflag_pkg.sv
package pflag_pkg;
  localparam int XLEN = 32;
  localparam int HALF = XLEN / 2;

  localparam int B_CARRY = 0;
  localparam int B_OVF   = 1;
  localparam int B_ZERO  = 2;
  localparam int B_SIGN  = 3;
  localparam int B_ODD   = 4;
  localparam int B_IEN   = 16;
  localparam int B_USER  = 17;
  localparam int B_PAGE  = 18;

  localparam int NCOND = B_ODD + 1;

  localparam logic [XLEN-1:0] LO_MASK   = 32'h0000_001F;
  localparam logic [XLEN-1:0] HI_MASK   = 32'h0007_0000;
  localparam logic [XLEN-1:0] IMPL_MASK = LO_MASK | HI_MASK;

  typedef struct packed {
    logic odd;
    logic sign;
    logic zero;
    logic ovf;
    logic carry;
  } cond_t;
endpackage

// File: rtl/pflag_cond.sv
module pflag_cond
  import pflag_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] result_i,
  input  logic         carry_i,
  input  logic         ovf_i,
  output cond_t        cond_o
);
  always_comb begin
    cond_o.carry = carry_i;
    cond_o.ovf   = ovf_i;
    cond_o.zero  = (result_i == '0);
    cond_o.sign  = result_i[W-1];
    cond_o.odd   = ^result_i;
  end
endmodule

// File: rtl/pflag_guard.sv
module pflag_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic user_mode_i,
  input  logic sw_wr_i,
  input  logic sw_be_hi_i,
  input  logic ien_set_i,
  input  logic ien_clr_i,
  output logic sw_ok_o,
  output logic ien_ok_o,
  output logic fault_o
);
  logic bad_sw, bad_ien, bad;

  always_comb begin
    bad_sw   = user_mode_i && sw_wr_i && sw_be_hi_i;
    bad_ien  = user_mode_i && (ien_set_i || ien_clr_i);
    bad      = bad_sw || bad_ien;
    sw_ok_o  = sw_wr_i && !bad_sw;
    ien_ok_o = !user_mode_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fault_o <= 1'b0;
    else        fault_o <= bad;
  end

  p_fault_raise_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> fault_o);
  p_fault_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |=> !fault_o);
endmodule

// File: rtl/pflag_reg.sv
module pflag_reg
  import pflag_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alu_upd_i,
  input  logic [XLEN-1:0] alu_result_i,
  input  logic            alu_carry_i,
  input  logic            alu_ovf_i,
  input  logic            sw_wr_i,
  input  logic            sw_be_lo_i,
  input  logic            sw_be_hi_i,
  input  logic [XLEN-1:0] sw_wdata_i,
  input  logic            ien_set_i,
  input  logic            ien_clr_i,
  input  logic            restore_i,
  input  logic [XLEN-1:0] restore_data_i,
  output logic [XLEN-1:0] flags_o,
  output logic            prot_fault_o
);
  logic [XLEN-1:0] flags_q, flags_d;
  cond_t           cond;
  logic            sw_ok, ien_ok;

  pflag_cond #(.W(XLEN)) u_cond (
    .result_i (alu_result_i),
    .carry_i  (alu_carry_i),
    .ovf_i    (alu_ovf_i),
    .cond_o   (cond)
  );

  pflag_guard u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .user_mode_i (flags_q[B_USER]),
    .sw_wr_i     (sw_wr_i),
    .sw_be_hi_i  (sw_be_hi_i),
    .ien_set_i   (ien_set_i),
    .ien_clr_i   (ien_clr_i),
    .sw_ok_o     (sw_ok),
    .ien_ok_o    (ien_ok),
    .fault_o     (prot_fault_o)
  );

  always_comb begin
    flags_d = flags_q;
    if (restore_i) begin
      flags_d = restore_data_i & IMPL_MASK;
    end else begin
      // condition half: software write, then ALU
      if (sw_ok && sw_be_lo_i)
        flags_d[HALF-1:0] = sw_wdata_i[HALF-1:0] & LO_MASK[HALF-1:0];
      else if (alu_upd_i)
        flags_d[NCOND-1:0] = cond;
      // control half: software write, then interrupt commands
      if (sw_ok && sw_be_hi_i)
        flags_d[XLEN-1:HALF] = sw_wdata_i[XLEN-1:HALF] & HI_MASK[XLEN-1:HALF];
      else if (ien_ok && ien_clr_i)
        flags_d[B_IEN] = 1'b0;
      else if (ien_ok && ien_set_i)
        flags_d[B_IEN] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o & ~IMPL_MASK) == '0);
  p_user_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_o[B_USER] && !restore_i) |=> $stable(flags_o[XLEN-1:HALF]));
  p_restore_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> flags_o == ($past(restore_data_i) & IMPL_MASK));
  p_alu_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_upd_i && !restore_i && !(sw_wr_i && sw_be_lo_i))
      |=> flags_o[B_CARRY] == $past(alu_carry_i));
endmodule

// File: tb/test_pflag_reg.sv
module test_pflag_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alu_upd = 0, alu_c = 0, alu_v = 0;
  logic [31:0] alu_res = '0;
  logic        sw_wr = 0, be_lo = 0, be_hi = 0;
  logic [31:0] sw_data = '0;
  logic        iset = 0, iclr = 0, rst_ld = 0;
  logic [31:0] rst_data = '0;
  logic [31:0] flags;
  logic        fault;

  int checks = 0, failures = 0;
  logic [31:0] exp_flags = '0;
  logic        exp_fault = 1'b0;

  always #10 clk = ~clk;

  pflag_reg i_pflag_reg (
    .clk(clk), .rst_n(rst_n),
    .alu_upd_i(alu_upd), .alu_result_i(alu_res), .alu_carry_i(alu_c), .alu_ovf_i(alu_v),
    .sw_wr_i(sw_wr), .sw_be_lo_i(be_lo), .sw_be_hi_i(be_hi), .sw_wdata_i(sw_data),
    .ien_set_i(iset), .ien_clr_i(iclr),
    .restore_i(rst_ld), .restore_data_i(rst_data),
    .flags_o(flags), .prot_fault_o(fault)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected next state from the requirements
  function automatic logic [32:0] model(input logic [31:0] cur);
    logic [31:0] n;
    logic user, bad_sw, bad_i, par;
    n = cur;
    user   = cur[17];
    bad_sw = user && sw_wr && be_hi;
    bad_i  = user && (iset || iclr);
    par = 1'b0;
    for (int k = 0; k < 32; k++) par ^= alu_res[k];
    if (rst_ld) n = rst_data & 32'h0007_001F;
    else begin
      if (sw_wr && !bad_sw && be_lo) n[4:0] = sw_data[4:0];
      else if (alu_upd) n[4:0] = {par, alu_res[31], alu_res == 0, alu_v, alu_c};
      if (sw_wr && !bad_sw && be_hi) n[18:16] = sw_data[18:16];
      else if (!user && iclr) n[16] = 1'b0;
      else if (!user && iset) n[16] = 1'b1;
    end
    return {bad_sw || bad_i, n};
  endfunction

  task automatic idle();
    alu_upd = 0; sw_wr = 0; be_lo = 0; be_hi = 0; iset = 0; iclr = 0; rst_ld = 0;
  endtask

  // inputs already set at negedge; clock once and compare with model
  task automatic cyc(input string tag);
    logic [32:0] m;
    m = model(exp_flags);
    @(posedge clk); #2;
    exp_flags = m[31:0];
    exp_fault = m[32];
    chk({tag, " flags"}, flags, exp_flags);
    chk({tag, " fault"}, {31'b0, fault}, {31'b0, exp_fault});
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 reset flags", flags, 32'h0);
    chk("R1 reset fault", {31'b0, fault}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #2;
    chk("R1 after reset", flags, 32'h0);
    @(negedge clk);

    // R2 flag computation
    alu_upd = 1; alu_res = 32'h0; alu_c = 1; cyc("R2 zero");
    chk("R2 zero value", flags, 32'h0000_0005);
    alu_upd = 1; alu_res = 32'h8000_0001; alu_v = 1; alu_c = 0; cyc("R2 neg even");
    chk("R2 neg even value", flags, 32'h0000_000A);
    alu_upd = 1; alu_res = 32'h0000_0007; alu_v = 0; cyc("R2 odd");
    chk("R2 odd value", flags, 32'h0000_0010);

    // R4 R3 low write in supervisor
    sw_wr = 1; be_lo = 1; sw_data = 32'hFFFF_FFFF; cyc("R4 lo write");
    chk("R3 R4 lo value", flags, 32'h0000_001F);
    // R10 software over ALU
    sw_wr = 1; be_lo = 1; sw_data = 32'h0000_0002; alu_upd = 1; alu_res = 0; alu_c = 1; cyc("R10 sw wins");
    chk("R10 value", flags, 32'h0000_0002);
    // R7 interrupt commands
    iset = 1; cyc("R7 set");
    chk("R7 set value", flags, 32'h0001_0002);
    iset = 1; iclr = 1; cyc("R7 both");
    chk("R7 clear wins", flags, 32'h0000_0002);
    // R5 supervisor hi write enters user mode
    sw_wr = 1; be_hi = 1; sw_data = 32'hFFFF_FFFF; cyc("R5 hi write");
    chk("R3 R5 hi value", flags, 32'h0007_0002);
    // R6 user hi write rejected, ALU still applies (R10)
    sw_wr = 1; be_hi = 1; be_lo = 1; sw_data = 32'h0; alu_upd = 1; alu_res = 32'h1; alu_c = 0; cyc("R6 reject");
    chk("R6 fault", {31'b0, fault}, 32'h1);
    chk("R10 faulted write lets ALU", flags, 32'h0007_0010);
    cyc("R11 quiet");
    chk("R11 fault drops", {31'b0, fault}, 32'h0);
    // R8
    iclr = 1; cyc("R8 clr");
    chk("R8 unchanged", flags, 32'h0007_0010);
    chk("R8 fault", {31'b0, fault}, 32'h1);
    // R4 user lo write allowed
    sw_wr = 1; be_lo = 1; sw_data = 32'h0000_0008; cyc("R4 user lo");
    chk("R4 user lo value", flags, 32'h0007_0008);
    // R9 restore over everything
    rst_ld = 1; rst_data = 32'hFFFF_FFFF; sw_wr = 1; be_lo = 1; be_hi = 1; sw_data = 0; alu_upd = 1; iclr = 1; cyc("R9 restore");
    chk("R9 value", flags, 32'h0007_001F);
    chk("R11 fault with restore", {31'b0, fault}, 32'h1);
    rst_ld = 1; rst_data = 32'h0; cyc("R9 back to supervisor");
    chk("R9 zero", flags, 32'h0);

    // random mix
    for (int i = 0; i < 2000; i++) begin
      alu_upd = $urandom_range(0, 1);
      alu_res = ($urandom_range(0, 7) == 0) ? 32'h0 : $urandom();
      alu_c = $urandom_range(0, 1); alu_v = $urandom_range(0, 1);
      sw_wr = ($urandom_range(0, 3) == 0); be_lo = $urandom_range(0, 1); be_hi = $urandom_range(0, 1);
      sw_data = $urandom();
      iset = ($urandom_range(0, 5) == 0); iclr = ($urandom_range(0, 5) == 0);
      rst_ld = ($urandom_range(0, 9) == 0); rst_data = $urandom();
      cyc("R2 R6 R7 R8 R9 R10 R11 random");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule